// File: doc/BRIEF.md
# Fixed-Period Reload PWM Generator

This block drives one pin with a pulse-width-modulated square wave whose period stays constant while its duty changes. A single up-counter of `CNT_W` bits (16 by default) runs from a loaded value to its all-ones state. On the next edge it wraps, and the wrap flips the output phase. The counter does not count on that edge. It is loaded instead with the start value that belongs to the new phase.

When the output enters its high phase, the counter takes the negated duty. When the output enters its low phase, it takes the duty itself. As a result, the high time is the duty and the low time is the rest of a 2^CNT_W-cycle period.

The duty request is limited to a usable window that leaves fixed service overhead at both ends: 19 at the bottom and 14 below the full count at the top. The request is captured once per period, at the rising edge of the output. A one-cycle strobe marks the start of every period so that a consumer can align to it. The output is usually filtered externally to form a coarse voltage output.

Top module: `pwm_reload_gen`

## Requirements
- R1: While reset is asserted, the output and the strobe are low and the counter is cleared. After reset, the first high phase begins only after exactly 2^CNT_W cycles with enable high.
- R2: With enable held high, successive period strobes are exactly 2^CNT_W cycles apart.
- R3: A high phase lasts exactly the effective duty in cycles. Within the usable window, the effective duty is the requested value.
- R4: A low phase that follows an uninterrupted high phase lasts exactly 2^CNT_W minus the effective duty of that high phase.
- R5: A duty request below 19, including 0, gives a high phase of 19 cycles.
- R6: A duty request above 2^CNT_W−14, including all-ones, gives a high phase of 2^CNT_W−14 cycles.
- R7: The duty input is sampled only on the cycle in which the output turns high. A change during a period does not affect that period's high or low time.
- R8: `periodStrobe` is high for exactly one cycle, the first cycle of each high phase. The output never turns high without it.
- R9: While enable is low, the output is low in the same cycle and the counter holds its value. After enable returns, the block resumes in the low phase from the held count, so the next high phase starts after the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the counter and forces the output low |
| dutyIn | input | CNT_W | Requested high time in cycles, sampled when a period starts |
| pwmOut | output | 1 | PWM waveform |
| periodStrobe | output | 1 | One-cycle pulse on the first high cycle of each period |

## Verification
The hardest conditions to reach from the ports are a duty change that arrives while a high phase is in progress and an enable drop part-way through a high phase. The first condition exercises R7. The second forces a resume from a held, mid-range count into the low phase, which exercises R9.

The bench reaches both conditions by waiting for a period strobe and acting a fixed number of cycles after it. It runs the design with an 8-bit counter so that many periods fit in the run. A behavioural phase-countdown model predicts the output and the strobe on every cycle. Separate measurements of high-run length, low-run length and strobe spacing check each boundary duty.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phaseT;

  // strobes from control to datapath
  typedef struct packed {
    logic count;     // advance the counter by one
    logic loadHigh;  // entering high phase: capture duty, load its negation
    logic loadLow;   // entering low phase: load the captured duty
  } pwmCtlT;

endpackage

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   cntAtMax,
  output pwmCtlT ctl,
  output logic   pwmOut,
  output logic   periodStrobe
);

  phaseT phase;
  logic  wrap;

  assign wrap = en && cntAtMax;

  always_comb begin
    ctl.count    = en && !wrap;
    ctl.loadHigh = wrap && (phase == PH_LOW);
    ctl.loadLow  = wrap && (phase == PH_HIGH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_LOW;
      periodStrobe <= 1'b0;
    end else begin
      periodStrobe <= ctl.loadHigh;
      if (!en)
        phase <= PH_LOW;
      else if (ctl.loadHigh)
        phase <= PH_HIGH;
      else if (ctl.loadLow)
        phase <= PH_LOW;
    end
  end

  assign pwmOut = (phase == PH_HIGH) && en;

endmodule

// File: rtl/pwm_reload_dp.sv
module pwm_reload_dp
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MIN_DUTY   = 19,
  parameter int TOP_MARGIN = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  pwmCtlT           ctl,
  input  logic [CNT_W-1:0] dutyIn,
  output logic             cntAtMax
);

  localparam logic [CNT_W-1:0] DUTY_LO = CNT_W'(MIN_DUTY);
  localparam logic [CNT_W-1:0] DUTY_HI = CNT_W'((2 ** CNT_W) - TOP_MARGIN);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dutyHeld;
  logic [CNT_W-1:0] dutyEff;

  always_comb begin
    if (dutyIn < DUTY_LO)
      dutyEff = DUTY_LO;
    else if (dutyIn > DUTY_HI)
      dutyEff = DUTY_HI;
    else
      dutyEff = dutyIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dutyHeld <= DUTY_LO;
    end else if (ctl.loadHigh) begin
      dutyHeld <= dutyEff;
      cnt      <= '0 - dutyEff;
    end else if (ctl.loadLow) begin
      cnt      <= dutyHeld;
    end else if (ctl.count) begin
      cnt      <= cnt + 1'b1;
    end
  end

  assign cntAtMax = &cnt;

endmodule

// File: rtl/pwm_reload_gen.sv
module pwm_reload_gen
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MIN_DUTY   = 19,
  parameter int TOP_MARGIN = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] dutyIn,
  output logic             pwmOut,
  output logic             periodStrobe
);

  pwmCtlT ctl;
  logic   cntAtMax;

  pwm_reload_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .cntAtMax     (cntAtMax),
    .ctl          (ctl),
    .pwmOut       (pwmOut),
    .periodStrobe (periodStrobe)
  );

  pwm_reload_dp #(
    .CNT_W      (CNT_W),
    .MIN_DUTY   (MIN_DUTY),
    .TOP_MARGIN (TOP_MARGIN)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .dutyIn   (dutyIn),
    .cntAtMax (cntAtMax)
  );

endmodule

// File: rtl/pwm_reload_chk.sv
module pwm_reload_chk #(
  parameter int CNT_W      = 16,
  parameter int MIN_DUTY   = 19,
  parameter int TOP_MARGIN = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [CNT_W-1:0] dutyIn,
  input logic             pwmOut,
  input logic             periodStrobe
);

  localparam int          LEN_W  = CNT_W + 2;
  localparam logic [LEN_W-1:0] PERIOD = LEN_W'(2 ** CNT_W);
  localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_DUTY);
  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'((2 ** CNT_W) - TOP_MARGIN);
  localparam logic [LEN_W-1:0] SAT    = {LEN_W{1'b1}};

  logic [LEN_W-1:0] sinceStrobe;
  logic [LEN_W-1:0] highLen;
  logic             runOk;
  logic             highOk;
  logic             dutyUnused;

  assign dutyUnused = ^dutyIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceStrobe <= '0;
      highLen     <= '0;
      runOk       <= 1'b0;
      highOk      <= 1'b0;
    end else begin
      if (periodStrobe)
        sinceStrobe <= LEN_W'(1);
      else if (sinceStrobe != SAT)
        sinceStrobe <= sinceStrobe + 1'b1;

      if (!pwmOut)
        highLen <= '0;
      else if (highLen != SAT)
        highLen <= highLen + 1'b1;

      if (!en) begin
        runOk  <= 1'b0;
        highOk <= 1'b0;
      end else if (periodStrobe) begin
        runOk  <= 1'b1;
        highOk <= 1'b1;
      end
    end
  end

  // R1: reset leaves output and strobe low
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!pwmOut && !periodStrobe));

  // R9: disabled means low output in the same cycle
  a_r9_low_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |-> !pwmOut);

  // R8: strobe marks a high cycle
  a_r8_strobe_on_high: assert property (@(posedge clk) disable iff (rst)
    (periodStrobe && en) |-> pwmOut);

  // R8: output never rises without the strobe
  a_r8_rise_has_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(pwmOut) |-> periodStrobe);

  // R8: strobe lasts a single cycle
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
    periodStrobe |=> !periodStrobe);

  // R2: constant period under steady enable
  a_r2_fixed_period: assert property (@(posedge clk) disable iff (rst)
    (periodStrobe && en && runOk) |-> (sinceStrobe == PERIOD));

  // R3, R5, R6: high time stays in the clamped window
  a_r3_high_in_window: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwmOut) && en && highOk) |-> (highLen >= LEN_LO && highLen <= LEN_HI));

  always_comb begin
    if (!rst && dutyUnused === 1'bx && en) begin
      a_r7_duty_known: assert (1'b0);
    end
  end

endmodule

bind pwm_reload_gen pwm_reload_chk #(
  .CNT_W      (CNT_W),
  .MIN_DUTY   (MIN_DUTY),
  .TOP_MARGIN (TOP_MARGIN)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .en           (en),
  .dutyIn       (dutyIn),
  .pwmOut       (pwmOut),
  .periodStrobe (periodStrobe)
);

// File: tb/pwm_reload_gen_tb.sv
module pwm_reload_gen_tb;

  localparam int W    = 8;
  localparam int P    = 2 ** W;
  localparam int DLO  = 19;
  localparam int DHI  = P - 14;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] dutyIn = W'(100);
  logic         pwmOut;
  logic         periodStrobe;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwm_reload_gen #(.CNT_W(W), .MIN_DUTY(DLO), .TOP_MARGIN(14)) u_dut (
    .clk (clk), .rst (rst), .en (en), .dutyIn (dutyIn),
    .pwmOut (pwmOut), .periodStrobe (periodStrobe)
  );

  function automatic int clampDuty(int d);
    if (d < DLO) return DLO;
    if (d > DHI) return DHI;
    return d;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural model: phase with a countdown of remaining cycles
  bit mHi = 0;
  bit mStrobe = 0;
  int mRem = P;
  int mDuty = DLO;
  int mReq = 0;
  int enCount = 0;

  always @(posedge clk) begin
    cycles++;
    mStrobe = 0;
    if (rst) begin
      mHi = 0; mRem = P; mDuty = DLO; mReq = 0; enCount = 0;
    end else if (en) begin
      enCount++;
      mRem--;
      if (mRem == 0) begin
        if (!mHi) begin
          mReq = int'(dutyIn);
          mDuty = clampDuty(mReq);
          mHi = 1; mRem = mDuty; mStrobe = 1;
        end else begin
          mHi = 0; mRem = P - mDuty;
        end
      end
    end else begin
      mHi = 0;
    end
  end

  // run-length bookkeeping at the sampling edge
  bit prevOut = 0;
  int highRun = 0, lowRun = 0, sinceStb = 0;
  bit hiIntr = 1, loIntr = 1, perOk = 0, firstDone = 0;
  int dutyAtFall = 0;

  always @(negedge clk) begin
    if (!finished) begin
      if (rst) begin
        check(!pwmOut && !periodStrobe, "R1 reset outputs", {pwmOut, periodStrobe}, 0);
        prevOut = 0; highRun = 0; lowRun = 0; sinceStb = 0;
        hiIntr = 1; loIntr = 1; perOk = 0; firstDone = 0;
      end else begin
        check(pwmOut == (mHi && en), "R3 R4 R7 R9 output vs model", pwmOut, int'(mHi && en));
        check(periodStrobe == mStrobe, "R8 strobe vs model", periodStrobe, mStrobe);
        if (!en) begin
          check(!pwmOut, "R9 low while disabled", pwmOut, 0);
          hiIntr = 1; loIntr = 1; perOk = 0;
        end
        if (periodStrobe) begin
          if (!firstDone) begin
            check(enCount == P, "R1 first high after full count", enCount, P);
            firstDone = 1;
          end
          if (perOk) check(sinceStb == P, "R2 period length", sinceStb, P);
          if (!loIntr) check(lowRun == P - dutyAtFall, "R4 low length", lowRun, P - dutyAtFall);
          sinceStb = 0; perOk = en; hiIntr = !en; highRun = 0;
        end
        if (pwmOut) highRun++;
        else lowRun++;
        if (prevOut && !pwmOut && en) begin
          if (!hiIntr) begin
            if (mReq < DLO)      check(highRun == DLO, "R5 floor high length", highRun, DLO);
            else if (mReq > DHI) check(highRun == DHI, "R6 ceiling high length", highRun, DHI);
            else                 check(highRun == mReq, "R3 R7 high length", highRun, mReq);
          end
          dutyAtFall = mDuty; lowRun = 1; loIntr = hiIntr;
        end
        sinceStb++;
        prevOut = pwmOut;
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 200000 && !finished) begin
      finished = 1;
      check(1'b0, "watchdog", cycles, 200000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive_step();
    @(posedge clk); #1;
  endtask

  task automatic waitStrobes(int n);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      if (periodStrobe) got++;
    end
    drive_step();
  endtask

  initial begin
    repeat (5) drive_step();
    rst = 0;
    repeat (4) drive_step();          // R9: disabled after reset, counter held
    en = 1;
    waitStrobes(4);                   // R1, R2, R3, R4 at duty 100
    dutyIn = W'(0);
    waitStrobes(3);                   // R5
    dutyIn = W'(255);
    waitStrobes(3);                   // R6
    dutyIn = W'(200);
    waitStrobes(1);
    repeat (5) drive_step();
    dutyIn = W'(40);                  // R7: change inside a high phase
    waitStrobes(3);
    dutyIn = W'(150);
    waitStrobes(1);
    repeat (10) drive_step();
    en = 0;                           // R9: drop enable mid-high
    repeat (37) drive_step();
    en = 1;
    waitStrobes(3);
    dutyIn = W'(DLO);
    waitStrobes(3);                   // R5 boundary exactly at floor
    dutyIn = W'(DHI);
    waitStrobes(3);                   // R6 boundary exactly at ceiling
    dutyIn = W'(18);
    waitStrobes(3);                   // R5 just below floor
    repeat (3) drive_step();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule